// File: doc/BRIEF.md
# Power-of-Two Dynamic Scale Estimator

The block watches a stream of single-precision (FP32) tensor elements, each tagged with a channel number, and derives a quantisation scale for an 8-bit floating-point target format. The scale is always a power of two, so the block reports only its integer exponent. A downstream converter can then apply the scale by adding to or subtracting from exponent fields, with no multiplier. For each scaling group the block keeps the largest finite magnitude seen. A group is either the whole tensor or a single channel. When an end-of-batch strobe arrives, the block turns each group's maximum into a scale exponent. It adds a power-of-two backoff margin for overflow headroom and emits the exponents one group per cycle, in channel order.

Two modes select where the scales come from. In dynamic mode the scales are recomputed from the measured maxima at every batch boundary. In static mode the block emits exponents that software has written into per-group holding registers, and the measured data has no influence. In both modes the maxima are cleared when a batch is closed, so each batch is measured from zero. Mode, granularity, target format and backoff are captured when a batch is closed. They may be changed freely while that batch's scales are being emitted.

Top module: `pow2_scale_estimator`

## Requirements
- R1: After reset `scale_valid` is 0, every static holding register reads 0, and each group's running maximum is 0.
- R2: Only finite, normal FP32 inputs (biased exponent field, bits 30:23, neither 0 nor 255) update a maximum. Zeros, subnormals, infinities and NaNs have no effect on it. Magnitude is bits 30:0, and the sign bit 31 is ignored.
- R3: In dynamic mode a nonzero maximum with exponent field E and mantissa field M gives `scale_exp` = (E − 127 + (M≠0 ? 1 : 0)) + `backoff_log2` − F. F is 8 when `fmt_sel`=0 (4-bit exponent format, largest value 448) and 15 when `fmt_sel`=1 (5-bit exponent format, largest value 57344). The result is a 9-bit two's-complement number.
- R4: In dynamic mode a group whose maximum is zero is emitted with `scale_exp` = 0.
- R5: With `per_chan`=0, a closed batch emits exactly one result with `scale_group`=0. In dynamic mode that result is computed from the maximum over all eligible elements, whatever their `in_chan`.
- R6: With `per_chan`=1, a closed batch emits NCH results on consecutive cycles, with `scale_group` counting 0, 1, … NCH−1. Each result uses only elements tagged with that channel. `scale_valid` then returns to 0.
- R7: If `batch_end` is sampled high at rising edge k while the block is idle, the first result is valid after edge k+1. An element presented in the same cycle as that `batch_end` belongs to the batch being closed.
- R8: Accepting a batch clears every maximum, so the next batch's results depend only on elements that arrive after it.
- R9: With `dyn_mode`=0, each result equals the holding register of its group (register 0 for the per-tensor case). A register is written by `st_wr` with `st_idx` and `st_exp`, and the element data has no effect.
- R10: A `batch_end` that arrives while results are still being emitted is ignored. Elements arriving during emission, including one in the same cycle as the ignored strobe, go into the next batch.
- R11: Mode, granularity, format and backoff are sampled when a batch is accepted. Changing them during emission does not alter that batch's results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Element strobe |
| in_value | input | 32 | FP32 element |
| in_chan | input | CW | Channel tag of the element (CW = clog2(NCH)) |
| batch_end | input | 1 | Close the current batch and emit its scales |
| dyn_mode | input | 1 | 1 = compute scales from data, 0 = emit holding registers |
| per_chan | input | 1 | 1 = one group per channel, 0 = one group for the tensor |
| fmt_sel | input | 1 | Target format: 0 = 4-bit exponent, 1 = 5-bit exponent |
| backoff_log2 | input | 3 | Headroom margin as a power-of-two exponent |
| st_wr | input | 1 | Write strobe for a static holding register |
| st_idx | input | CW | Holding register index |
| st_exp | input | 9 | Static scale exponent, two's complement |
| scale_valid | output | 1 | A scale result is present |
| scale_group | output | CW | Group of the present result |
| scale_exp | output | 9 | Scale exponent, two's complement |

## Verification
The hardest situation to reach from the ports is an end-of-batch strobe that lands while a per-channel emission is in progress, together with an element in that same cycle. Both must be treated correctly: the strobe is dropped and the element is carried into the following batch. The bench drives this strobe and element on purpose in the third emission cycle. It then checks that the run of results continues unbroken, and that the next batch's result for that channel reflects the carried-over element. The bench also places an element in the closing cycle itself, and changes format and backoff immediately after a batch is accepted, to check the capture edge on both sides.

// File: rtl/scale_pkg.sv
// Package: shared types and helpers for the power-of-two scale estimator.
// Assumes FP32 elements in the usual sign/8-bit exponent/23-bit fraction layout.
package scale_pkg;

    localparam int MAG_W = 31;   // magnitude bits of an FP32 word
    localparam int EXP_W = 9;    // width of a scale exponent
    localparam int BO_W  = 3;    // width of the backoff exponent

    typedef enum logic {
        FMT_E4M3 = 1'b0,
        FMT_E5M2 = 1'b1
    } fp8_fmt_e;

    // Settings captured when a batch is accepted
    typedef struct packed {
        logic            dyn;
        logic            per_chan;
        fp8_fmt_e        fmt;
        logic [BO_W-1:0] backoff;
    } batch_cfg_t;

    // Exponent of the largest power of two not above the format's largest value
    function automatic logic signed [9:0] fmt_emax(fp8_fmt_e f);
        return (f == FMT_E5M2) ? 10'sd15 : 10'sd8;
    endfunction

    // True for finite normal FP32 values (exponent field neither 0 nor all ones)
    function automatic logic is_finite_normal(logic [31:0] v);
        return (v[30:23] != 8'h00) && (v[30:23] != 8'hFF);
    endfunction

endpackage

// File: rtl/amax_tracker.sv
// Module: amax_tracker
// Keeps the running maximum magnitude of each scaling group. In per-tensor
// mode all elements fold into slot 0. It presents the maxima with the current
// element already applied, so that a snapshot taken in the closing cycle
// includes that element. Assumes per_chan is stable within a batch.
module amax_tracker
    import scale_pkg::*;
#(
    parameter int NCH = 16,
    parameter int CW  = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    input  logic [31:0]                    in_value,
    input  logic [CW-1:0]                  in_chan,
    input  logic                           per_chan,
    input  logic                           clear,
    output logic [NCH-1:0][MAG_W-1:0]      amax_next
);

    logic [NCH-1:0][MAG_W-1:0] amax_q;
    logic                      eligible;
    logic [CW-1:0]             slot;

    // Decide whether and where the current element lands
    always_comb begin
        eligible = in_valid && is_finite_normal(in_value);
        slot     = per_chan ? in_chan : '0;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_slot
        // Candidate maximum for this group with the current element applied
        always_comb begin
            if (eligible && (slot == CW'(g)) && (in_value[MAG_W-1:0] > amax_q[g]))
                amax_next[g] = in_value[MAG_W-1:0];
            else
                amax_next[g] = amax_q[g];
        end

        // R8: only a batch accept may lower a maximum
        p_amax_no_decrease_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(clear)) |-> (amax_q[g] >= $past(amax_q[g])));

        // R2: a non-finite value never becomes a maximum
        p_amax_finite_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (amax_q[g][30:23] != 8'hFF));

        // R2: with no element and no accept, maxima hold
        p_amax_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(in_valid) && !$past(clear)) |-> $stable(amax_q[g]));
    end

    // Maxima registers: cleared on reset and on batch accept
    always_ff @(posedge clk) begin
        if (!rst_n)
            amax_q <= '0;
        else if (clear)
            amax_q <= '0;
        else
            amax_q <= amax_next;
    end

endmodule

// File: rtl/static_scale_bank.sv
// Module: static_scale_bank
// Holds one software-written scale exponent per group for static mode.
// A single write port and a single combinational read port.
module static_scale_bank
    import scale_pkg::*;
#(
    parameter int NCH = 16,
    parameter int CW  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [CW-1:0]           wr_idx,
    input  logic signed [EXP_W-1:0] wr_exp,
    input  logic [CW-1:0]           rd_idx,
    output logic signed [EXP_W-1:0] rd_exp
);

    logic signed [EXP_W-1:0] regs_q [NCH];

    // Register writes; indices beyond NCH are dropped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) regs_q[i] <= '0;
        end else if (wr_en && (int'(wr_idx) < NCH)) begin
            regs_q[wr_idx] <= wr_exp;
        end
    end

    // Read port
    always_comb begin
        rd_exp = (int'(rd_idx) < NCH) ? regs_q[rd_idx] : '0;
    end

endmodule

// File: rtl/scale_calc.sv
// Module: scale_calc
// Turns a maximum magnitude into ceil(log2(amax)) + backoff - format exponent.
// Assumes the magnitude is zero or a finite normal FP32 magnitude.
module scale_calc
    import scale_pkg::*;
(
    input  logic [MAG_W-1:0]        mag,
    input  fp8_fmt_e                fmt,
    input  logic [BO_W-1:0]         backoff,
    output logic signed [EXP_W-1:0] exp_o
);

    logic signed [9:0] ceil_e;
    logic signed [9:0] res;

    // Ceiling log2 from exponent field, then margin and format offset
    always_comb begin
        ceil_e = $signed({2'b00, mag[30:23]}) - 10'sd127
               + $signed({9'd0, |mag[22:0]});
        res    = ceil_e + $signed({7'd0, backoff}) - fmt_emax(fmt);
        exp_o  = (mag == '0) ? '0 : res[EXP_W-1:0];
    end

endmodule

// File: rtl/emit_sequencer.sv
// Module: emit_sequencer
// Accepts a batch close when idle, snapshots maxima and settings, then walks
// the groups one per cycle and registers each result. A close that arrives
// while walking is ignored.
module emit_sequencer
    import scale_pkg::*;
#(
    parameter int NCH = 16,
    parameter int CW  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       batch_end,
    input  batch_cfg_t                 cfg_in,
    input  logic [NCH-1:0][MAG_W-1:0]  amax_in,
    input  logic signed [EXP_W-1:0]    dyn_exp,
    input  logic signed [EXP_W-1:0]    static_exp,
    output logic                       accept,
    output logic [CW-1:0]              cur_idx,
    output logic [MAG_W-1:0]           cur_amax,
    output batch_cfg_t                 cur_cfg,
    output logic                       scale_valid,
    output logic [CW-1:0]              scale_group,
    output logic signed [EXP_W-1:0]    scale_exp
);

    logic                      busy_q;
    logic [CW-1:0]             cnt_q;
    logic [NCH-1:0][MAG_W-1:0] snap_q;
    batch_cfg_t                snap_cfg_q;
    logic [CW-1:0]             last_idx;

    // Accept decision and current group selection
    always_comb begin
        accept   = batch_end && !busy_q;
        last_idx = snap_cfg_q.per_chan ? CW'(NCH - 1) : '0;
        cur_idx  = cnt_q;
        cur_amax = snap_q[cnt_q];
        cur_cfg  = snap_cfg_q;
    end

    // Snapshot on accept, then step through the groups
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            cnt_q      <= '0;
            snap_q     <= '0;
            snap_cfg_q <= '0;
        end else if (accept) begin
            busy_q     <= 1'b1;
            cnt_q      <= '0;
            snap_q     <= amax_in;
            snap_cfg_q <= cfg_in;
        end else if (busy_q) begin
            cnt_q <= cnt_q + CW'(1);
            if (cnt_q == last_idx) busy_q <= 1'b0;
        end
    end

    // Output register: one result per walking cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scale_valid <= 1'b0;
            scale_group <= '0;
            scale_exp   <= '0;
        end else begin
            scale_valid <= busy_q;
            scale_group <= cnt_q;
            scale_exp   <= snap_cfg_q.dyn ? dyn_exp : static_exp;
        end
    end

    // R6: consecutive results count groups upward
    p_group_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (scale_valid && $past(scale_valid)) |-> (scale_group == $past(scale_group) + CW'(1)));

    // R6: every run of results starts at group 0
    p_first_group_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scale_valid) |-> (scale_group == '0));

    // R5: per-tensor batches only ever report group 0
    p_tensor_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (scale_valid && !snap_cfg_q.per_chan) |-> (scale_group == '0));

    // R10: a close during walking leaves the walk running
    p_close_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && batch_end && (cnt_q != last_idx)) |=> (busy_q && (cnt_q == $past(cnt_q) + CW'(1))));

endmodule

// File: rtl/pow2_scale_estimator.sv
// Module: pow2_scale_estimator (top)
// Per-batch power-of-two scale estimation for an 8-bit float target, per
// tensor or per channel, from measured maxima or from static registers.
// Assumes settings other than those sampled at accept are stable per batch.
module pow2_scale_estimator
    import scale_pkg::*;
#(
    parameter int  NCH = 16,
    localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [31:0]             in_value,
    input  logic [CW-1:0]           in_chan,
    input  logic                    batch_end,
    input  logic                    dyn_mode,
    input  logic                    per_chan,
    input  logic                    fmt_sel,
    input  logic [2:0]              backoff_log2,
    input  logic                    st_wr,
    input  logic [CW-1:0]           st_idx,
    input  logic signed [8:0]       st_exp,
    output logic                    scale_valid,
    output logic [CW-1:0]           scale_group,
    output logic signed [8:0]       scale_exp
);

    batch_cfg_t                cfg_live;
    batch_cfg_t                cur_cfg;
    logic                      accept;
    logic [NCH-1:0][MAG_W-1:0] amax_next;
    logic [CW-1:0]             cur_idx;
    logic [MAG_W-1:0]          cur_amax;
    logic signed [EXP_W-1:0]   dyn_exp;
    logic signed [EXP_W-1:0]   static_exp;

    // Gather the live settings into one capture word
    always_comb begin
        cfg_live.dyn      = dyn_mode;
        cfg_live.per_chan = per_chan;
        cfg_live.fmt      = fp8_fmt_e'(fmt_sel);
        cfg_live.backoff  = backoff_log2;
    end

    amax_tracker #(.NCH(NCH), .CW(CW)) i_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_value  (in_value),
        .in_chan   (in_chan),
        .per_chan  (per_chan),
        .clear     (accept),
        .amax_next (amax_next)
    );

    static_scale_bank #(.NCH(NCH), .CW(CW)) i_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (st_wr),
        .wr_idx (st_idx),
        .wr_exp (st_exp),
        .rd_idx (cur_idx),
        .rd_exp (static_exp)
    );

    scale_calc i_calc (
        .mag     (cur_amax),
        .fmt     (cur_cfg.fmt),
        .backoff (cur_cfg.backoff),
        .exp_o   (dyn_exp)
    );

    emit_sequencer #(.NCH(NCH), .CW(CW)) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .batch_end   (batch_end),
        .cfg_in      (cfg_live),
        .amax_in     (amax_next),
        .dyn_exp     (dyn_exp),
        .static_exp  (static_exp),
        .accept      (accept),
        .cur_idx     (cur_idx),
        .cur_amax    (cur_amax),
        .cur_cfg     (cur_cfg),
        .scale_valid (scale_valid),
        .scale_group (scale_group),
        .scale_exp   (scale_exp)
    );

    // R4: a zero maximum in dynamic mode yields exponent 0
    p_zero_amax_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(i_seq.busy_q) && $past(cur_cfg.dyn) && ($past(cur_amax) == '0))
        |-> (scale_exp == '0));

endmodule

// File: tb/test_pow2_scale_estimator.sv
// Bench for pow2_scale_estimator: seeded random batches plus directed corners,
// compared against a bench-side model of maxima and exponents.
module test_pow2_scale_estimator;

    localparam int NCH = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              in_valid;
    logic [31:0]       in_value;
    logic [3:0]        in_chan;
    logic              batch_end;
    logic              dyn_mode;
    logic              per_chan;
    logic              fmt_sel;
    logic [2:0]        backoff_log2;
    logic              st_wr;
    logic [3:0]        st_idx;
    logic signed [8:0] st_exp;
    logic              scale_valid;
    logic [3:0]        scale_group;
    logic signed [8:0] scale_exp;

    int checks = 0;
    int fails  = 0;

    logic [30:0]       m_amax   [NCH];
    logic signed [8:0] m_static [NCH];
    logic signed [8:0] exp_q    [NCH];

    always #5 clk = ~clk;

    pow2_scale_estimator #(.NCH(NCH)) i_pow2_scale_estimator (
        .clk, .rst_n, .in_valid, .in_value, .in_chan, .batch_end, .dyn_mode,
        .per_chan, .fmt_sel, .backoff_log2, .st_wr, .st_idx, .st_exp,
        .scale_valid, .scale_group, .scale_exp
    );

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic signed [8:0] ref_exp(logic [30:0] m, logic f, logic [2:0] bo);
        int c;
        if (m == 31'd0) return 9'sd0;
        c = int'(m[30:23]) - 127 + ((m[22:0] != 23'd0) ? 1 : 0);
        c = c + int'(bo) - (f ? 15 : 8);
        return 9'(c);
    endfunction

    function automatic void model_add(int ch, logic [31:0] v);
        int slot;
        if (v[30:23] == 8'h00 || v[30:23] == 8'hFF) return;
        slot = per_chan ? ch : 0;
        if (v[30:0] > m_amax[slot]) m_amax[slot] = v[30:0];
    endfunction

    function automatic logic [31:0] rnd_val();
        int unsigned sel = $urandom % 16;
        logic [31:0] v;
        v[31]    = 1'($urandom);
        v[22:0]  = 23'($urandom);
        if (sel == 0)      begin v[30:23] = 8'h00; v[22:0] = '0; end
        else if (sel == 1) v[30:23] = 8'hFF;
        else if (sel == 2) v[30:23] = 8'h00;
        else               v[30:23] = 8'(1 + ($urandom % 254));
        return v;
    endfunction

    // Present one element for one cycle (called at a falling edge)
    task automatic send(int ch, logic [31:0] v);
        in_valid = 1'b1; in_chan = 4'(ch); in_value = v;
        model_add(ch, v);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic write_static(int idx, logic signed [8:0] v);
        st_wr = 1'b1; st_idx = 4'(idx); st_exp = v;
        @(negedge clk);
        st_wr = 1'b0;
        m_static[idx] = v;
    endtask

    // Close a batch and check its results; optional same-cycle element,
    // mid-emission close with element, and setting change after accept
    task automatic close_batch(string tag, bit with_elem, int ech, logic [31:0] ev,
                               bit poke, bit cfg_flip);
        int ng;
        batch_end = 1'b1;
        if (with_elem) begin
            in_valid = 1'b1; in_chan = 4'(ech); in_value = ev;
            model_add(ech, ev);
        end
        ng = per_chan ? NCH : 1;
        for (int i = 0; i < ng; i++)
            exp_q[i] = dyn_mode ? ref_exp(m_amax[i], fmt_sel, backoff_log2) : m_static[i];
        for (int i = 0; i < NCH; i++) m_amax[i] = '0;
        @(negedge clk);
        batch_end = 1'b0; in_valid = 1'b0;
        if (cfg_flip) begin
            fmt_sel = ~fmt_sel;
            backoff_log2 = backoff_log2 + 3'd3;
        end
        chk("R7", "valid one cycle after accept", int'(scale_valid), 0);
        for (int i = 0; i < ng; i++) begin
            @(negedge clk);
            chk("R7", "valid during emission", int'(scale_valid), 1);
            chk(per_chan ? "R6" : "R5", "group", int'(scale_group), i);
            chk(tag, "exponent", int'(scale_exp), int'(exp_q[i]));
            if (poke && i == 2) begin
                batch_end = 1'b1; in_valid = 1'b1; in_chan = 4'd5;
                in_value = 32'h4A000000;
                model_add(5, in_value);
            end else if (poke && i == 3) begin
                batch_end = 1'b0; in_valid = 1'b0;
            end
        end
        @(negedge clk);
        chk(per_chan ? "R6" : "R5", "valid after last group", int'(scale_valid), 0);
    endtask

    task automatic random_batch(string tag, int n);
        for (int k = 0; k < n; k++) send($urandom % NCH, rnd_val());
        close_batch(tag, 1'b0, 0, 32'h0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R7 watchdog: actual=timeout expected=completion");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd20240611);
        rst_n = 1'b0; in_valid = 1'b0; in_value = '0; in_chan = '0;
        batch_end = 1'b0; dyn_mode = 1'b0; per_chan = 1'b1; fmt_sel = 1'b0;
        backoff_log2 = '0; st_wr = 1'b0; st_idx = '0; st_exp = '0;
        for (int i = 0; i < NCH; i++) begin m_amax[i] = '0; m_static[i] = '0; end
        repeat (3) @(negedge clk);
        chk("R1", "valid in reset", int'(scale_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "valid after reset", int'(scale_valid), 0);

        // R1, R9: static registers read zero after reset, data ignored
        send(2, 32'h42000000);
        close_batch("R1", 1'b0, 0, 32'h0, 1'b0, 1'b0);

        // R9: static values written, per channel then per tensor
        for (int i = 0; i < NCH; i++) write_static(i, 9'($urandom));
        random_batch("R9", 20);
        per_chan = 1'b0;
        random_batch("R9", 10);

        // R1: maxima start at zero (nothing sent since last close)
        dyn_mode = 1'b1;
        close_batch("R1", 1'b0, 0, 32'h0, 1'b0, 1'b0);

        // R3, R5: directed exponent corners per tensor
        fmt_sel = 1'b0; backoff_log2 = 3'd7;
        send(0, 32'h7F7FFFFF);                       // largest finite: 128+7-8
        close_batch("R3", 1'b0, 0, 32'h0, 1'b0, 1'b0);
        fmt_sel = 1'b1; backoff_log2 = 3'd0;
        send(9, 32'h00800000);                       // smallest normal: -126-15
        close_batch("R3", 1'b0, 0, 32'h0, 1'b0, 1'b0);
        fmt_sel = 1'b0;
        send(1, 32'h43E00000);                       // 448 -> 1
        send(7, 32'hC3800000);                       // -256 -> 0, smaller
        close_batch("R3", 1'b0, 0, 32'h0, 1'b0, 1'b0);

        // R5, R8: random per-tensor batches across settings
        for (int b = 0; b < 8; b++) begin
            fmt_sel = 1'($urandom); backoff_log2 = 3'($urandom);
            random_batch("R5", 30);
        end

        // R2, R4: only ineligible inputs, then one normal among specials
        per_chan = 1'b1; fmt_sel = 1'b0; backoff_log2 = 3'd2;
        send(3, 32'h7FC00000);
        send(3, 32'hFF800000);
        send(3, 32'h00000001);
        send(3, 32'h80000000);
        send(4, 32'h3F800000);
        send(4, 32'h7F800000);
        close_batch("R2", 1'b0, 0, 32'h0, 1'b0, 1'b0);
        send(6, 32'h7FFFFFFF);
        close_batch("R4", 1'b0, 0, 32'h0, 1'b0, 1'b0);

        // R6: random per-channel batches
        for (int b = 0; b < 6; b++) begin
            fmt_sel = 1'($urandom); backoff_log2 = 3'($urandom);
            random_batch("R6", 40);
        end

        // R7: element in the closing cycle belongs to that batch
        send(8, 32'h3F800000);
        close_batch("R7", 1'b1, 8, 32'h45000000, 1'b0, 1'b0);

        // R10: close and element during emission; element lands in next batch
        send(5, 32'h3F800000);
        close_batch("R10", 1'b0, 0, 32'h0, 1'b1, 1'b0);
        close_batch("R10", 1'b0, 0, 32'h0, 1'b0, 1'b0);

        // R11: settings changed right after accept do not affect results
        send(0, 32'h41200000);
        send(11, 32'h49000000);
        close_batch("R11", 1'b0, 0, 32'h0, 1'b0, 1'b1);
        per_chan = 1'b0;
        send(2, 32'h44800000);
        close_batch("R11", 1'b0, 0, 32'h0, 1'b0, 1'b1);

        // R8: batch after a large one starts clean
        send(1, 32'h3E000000);
        close_batch("R8", 1'b0, 0, 32'h0, 1'b0, 1'b0);

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule